// File: doc/BRIEF.md
# UART Modem Status Register Logic

This block produces the 8-bit modem status byte of a UART host interface. Four active-low modem input pins feed it: clear-to-send, data-set-ready, ring indicator and carrier detect. The upper nibble shows the current asserted state of each line, which is the inverse of the pin level. The lower nibble holds sticky change flags. A flag records that its line has changed since the host last read the byte, and the read clears it.

In loopback mode the pins are disconnected from the status path. The four low bits of the modem control register drive the status instead. The block also raises a level-sensitive modem status interrupt request whenever a change flag is set and the host has enabled that interrupt. The host read strobe, the loopback select, the control bits and the enable bit come from the surrounding register file. This block only consumes them.

Top module: `modem_status_unit`

## Requirements
- R1: Outside loopback, status bits 4, 5, 6 and 7 equal the inverted levels of the CTS, DSR, RI and CD pins in that order. A pin change becomes visible on the third rising clock edge after it, because of a two-flop synchroniser and one status register.
- R2: In loopback mode, status bits 4 to 7 equal modem control bits 0 to 3 one clock after they are presented. The pins have no effect on the status byte while loopback is selected.
- R3: Bit 0 (CTS), bit 1 (DSR) and bit 3 (CD) are set when the matching status bit changes in either direction.
- R4: Bit 2 is set only when the RI status bit falls from 1 to 0. A 0-to-1 change of RI status leaves bit 2 unchanged.
- R5: A set change flag stays set until a host read. All change flags are cleared on the clock edge that samples the read strobe high.
- R6: A change detected on the same edge as a read leaves its flag set after that read.
- R7: Entering or leaving loopback updates the status bits from the newly selected source. Each resulting difference sets its change flag under the rules of R3 and R4.
- R8: The interrupt request is high exactly when the enable input is 1 and at least one change flag is set.
- R9: After reset, with all pins inactive (high), the status byte is 0x00 and the interrupt request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_n | input | 4 | Modem pins, active low: [0] CTS, [1] DSR, [2] RI, [3] CD |
| loopback_en | input | 1 | Selects the modem control bits as the status source |
| mcr_bits | input | 4 | Modem control bits: [0] RTS, [1] DTR, [2] OUT1, [3] OUT2 |
| msr_rd | input | 1 | One-cycle strobe marking a host read of the status byte |
| int_en | input | 1 | Modem status interrupt enable |
| msr_q | output | 8 | Status byte: [7:4] line state, [3:0] change flags |
| irq_o | output | 1 | Modem status interrupt request, level |

## Verification
The assertions assume that the read strobe, the loopback select and the control bits come from the same clock domain and change only between edges. Only the modem pins are treated as asynchronous. The bench drives every input on the falling edge, so no input moves near a sampling edge. It holds the pins inactive through reset, which keeps the synchroniser's reset value consistent with the pins. It samples on the falling edge after counting the synchroniser and status register stages.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINES = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_CD  = 3;

  // Change mask between two status snapshots: any toggle counts,
  // except the ring line which reports only its 1 -> 0 transition.
  function automatic logic [LINES-1:0] delta_mask(input logic [LINES-1:0] prev_s,
                                                  input logic [LINES-1:0] next_s);
    logic [LINES-1:0] d;
    d = prev_s ^ next_s;
    d[IDX_RI] = prev_s[IDX_RI] & ~next_s[IDX_RI];
    return d;
  endfunction

  function automatic logic any_set(input logic [LINES-1:0] v);
    return |v;
  endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  // Idle pins are high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/msr_src_mux.sv
module msr_src_mux #(
  parameter int W = 4
) (
  input  logic         loop_sel,
  input  logic [W-1:0] pins_sync_n,
  input  logic [W-1:0] ctrl_bits,
  output logic [W-1:0] live_stat
);
  for (genvar i = 0; i < W; i++) begin : g_line
    assign live_stat[i] = loop_sel ? ctrl_bits[i] : ~pins_sync_n[i];
  end
endmodule

// File: rtl/msr_delta.sv
module msr_delta
  import msr_pkg::*;
#(
  parameter int W = LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live_stat,
  input  logic         rd_clr,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] chg_evt
);
  assign chg_evt = delta_mask(stat_q, live_stat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      flag_q <= '0;
    end else begin
      stat_q <= live_stat;
      flag_q <= (rd_clr ? '0 : flag_q) | chg_evt;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R3
    flag_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> $past(chg_evt[i]));
    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !chg_evt[i]) |=> !flag_q[i]);
    // R6
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_evt[i] |=> flag_q[i]);
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !rd_clr) |=> flag_q[i]);
  end

  // R4
  ring_trailing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[IDX_RI]) |-> ($past(stat_q[IDX_RI]) && !stat_q[IDX_RI]));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pins_n,
  input  logic             loopback_en,
  input  logic [LINES-1:0] mcr_bits,
  input  logic             msr_rd,
  input  logic             int_en,
  output logic [7:0]       msr_q,
  output logic             irq_o
);
  localparam int W = LINES;

  logic [W-1:0] pins_sync_n;
  logic [W-1:0] live_stat;
  logic [W-1:0] stat_q;
  logic [W-1:0] flag_q;
  logic [W-1:0] chg_evt;

  msr_sync #(.STAGES(SYNC_STAGES), .W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_n),
    .dout  (pins_sync_n)
  );

  msr_src_mux #(.W(W)) u_mux (
    .loop_sel    (loopback_en),
    .pins_sync_n (pins_sync_n),
    .ctrl_bits   (mcr_bits),
    .live_stat   (live_stat)
  );

  msr_delta #(.W(W)) u_delta (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_stat (live_stat),
    .rd_clr    (msr_rd),
    .stat_q    (stat_q),
    .flag_q    (flag_q),
    .chg_evt   (chg_evt)
  );

  assign msr_q = {stat_q, flag_q};
  assign irq_o = int_en & any_set(flag_q);

  // R2
  loop_follows_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_en |=> (msr_q[7:4] == $past(mcr_bits)));
  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (int_en && msr_q[3:0] != 4'h0));
  // R8
  irq_raised_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && msr_q[3:0] != 4'h0) |-> irq_o);
endmodule

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins_n = 4'hF;
  logic       loopback_en = 1'b0;
  logic [3:0] mcr_bits = 4'h0;
  logic       msr_rd = 1'b0;
  logic       int_en = 1'b0;
  logic [7:0] msr_q;
  logic       irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] rd_val;

  always #10 clk = ~clk;

  modem_status_unit i_modem_status_unit (
    .clk(clk), .rst_n(rst_n), .pins_n(pins_n), .loopback_en(loopback_en),
    .mcr_bits(mcr_bits), .msr_rd(msr_rd), .int_en(int_en),
    .msr_q(msr_q), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Host read: captures the byte, strobe sampled on the next rising edge.
  task automatic host_read();
    rd_val = msr_q;
    msr_rd = 1'b1;
    tick(1);
    msr_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset status", msr_q, 8'h00);
    chk("R9 reset irq", {7'd0, irq_o}, 8'h00);
  endtask

  task automatic t_pin_path();
    pins_n = 4'b1110;               // CTS asserted
    tick(2);
    chk("R1 latency two edges", msr_q, 8'h00);
    tick(1);
    chk("R1 R3 cts visible and flagged", msr_q, 8'h11);
    tick(4);
    chk("R5 flag held without read", msr_q, 8'h11);
    host_read();
    chk("R5 read returned flag", rd_val, 8'h11);
    chk("R5 flags cleared after read", msr_q, 8'h10);
    pins_n = 4'b1111;               // CTS released: falling status also flags
    tick(3);
    chk("R3 cts deassert flagged", msr_q, 8'h01);
    host_read();
  endtask

  task automatic t_dsr_cd();
    pins_n = 4'b0101;               // DSR and CD asserted
    tick(3);
    chk("R1 R3 dsr cd set", msr_q, 8'hAA);
    host_read();
    pins_n = 4'b1111;
    tick(3);
    chk("R3 dsr cd release", msr_q, 8'h0A);
    host_read();
    chk("R5 clear", msr_q, 8'h00);
  endtask

  task automatic t_ring();
    pins_n = 4'b1011;               // RI asserted: status 0 -> 1
    tick(3);
    chk("R4 ri leading edge no flag", msr_q, 8'h40);
    pins_n = 4'b1111;               // status 1 -> 0
    tick(3);
    chk("R4 ri trailing edge flagged", msr_q, 8'h04);
    host_read();
  endtask

  task automatic t_irq();
    pins_n = 4'b0111;
    tick(3);
    chk("R8 irq masked", {7'd0, irq_o}, 8'h00);
    int_en = 1'b1;
    #1;
    chk("R8 irq asserted", {7'd0, irq_o}, 8'h01);
    host_read();
    chk("R8 irq drops after read", {7'd0, irq_o}, 8'h00);
    pins_n = 4'b1111;
    tick(3);
    host_read();
    int_en = 1'b0;
  endtask

  task automatic t_collide();
    pins_n = 4'b1110;
    tick(3);                        // CTS flag set
    pins_n = 4'b0110;               // CD change lands at third edge
    tick(2);
    host_read();                    // strobe sampled on that same edge
    chk("R6 cd flag survives read, cts cleared", msr_q, 8'h98);
    host_read();
    pins_n = 4'b1111;
    tick(3);
    host_read();
    chk("R6 cleanup", msr_q, 8'h00);
  endtask

  task automatic t_loopback();
    mcr_bits = 4'b1010;
    loopback_en = 1'b1;
    tick(1);
    chk("R2 R7 enter loopback", msr_q, 8'hAA);
    host_read();
    pins_n = 4'b0000;
    tick(4);
    chk("R2 pins ignored", msr_q, 8'hA0);
    pins_n = 4'b1110;               // only CTS asserted for the exit
    mcr_bits = 4'b0101;
    tick(1);
    chk("R2 R3 R4 ctrl change", msr_q, 8'h5B);
    host_read();
    tick(3);
    loopback_en = 1'b0;
    tick(1);
    chk("R7 exit loopback", msr_q, 8'h14);
    host_read();
    pins_n = 4'b1111;
    tick(3);
    host_read();
    chk("R7 cleanup", msr_q, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_pin_path();
    t_dsr_cd();
    t_ring();
    t_irq();
    t_collide();
    t_loopback();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule